// File: doc/BRIEF.md
# Fifteen-Level Priority Interrupt Controller

This block gathers interrupt requests on fifteen priority levels (1 to 15) and offers them to a processor one at a time, highest level first. A level is requesting when its pending bit or its software force bit is set and its mask bit is clear. Hardware sources set pending bits with single-cycle pulses. Software reads and writes the mask and force registers, reads the pending register, and clears pending bits through a write-one-to-clear register. All of this goes through a small register port.

Each offer is a one-cycle strobe on `irq_valid` together with a 4-bit level. Once a level has been offered, it is held back from further offers until the processor returns that level on the acknowledge port. An acknowledge also removes the source of the request. Normally it clears the pending bit. When the `test_mode` input is high and the force bit of that level is set, it clears the force bit instead.

Register port addresses: 0 reads the pending register (writes have no effect). 1 is the mask register. 2 is the force register. 3 is the clear register, which is write-only and reads as zero.

Top module: `irqc15_top`

## Requirements
- R1: Level 0 is never offered. Bit 0 of the pending and force registers always reads 0, and a request pulse on bit 0 has no effect.
- R2: When several levels are requesting and not yet offered, the highest one is offered first. The rest follow in descending order on later cycles.
- R3: An offered level is not offered again until an acknowledge carrying that level arrives. If the level is still requesting after the acknowledge, it is offered again.
- R4: The mask register resets to 0x3FFF, and a write keeps only data bits 14..1 (address 1). Level 15 therefore can never be masked. A masked level is not offered.
- R5: The force register resets to 0 and a write keeps data bits 15..1 (address 2). It reads back what was stored.
- R6: With `test_mode` low, acknowledging level L clears pending bit L and leaves force bit L unchanged.
- R7: With `test_mode` high, acknowledging level L clears force bit L if that bit is set. If force bit L is clear, the acknowledge clears pending bit L.
- R8: A request pulse on `req_pulse[L]` sets pending bit L. When a clear write or an acknowledge for bit L falls in the same cycle, the set wins.
- R9: A write to the clear register (address 3) clears the pending bits whose data bits are 1 and leaves the others unchanged.
- R10: A request pulse sampled at clock edge k raises `irq_valid` after edge k+1, not earlier. The pending register and all outputs reset to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_pulse | input | 16 | Hardware request pulses, one bit per level |
| test_mode | input | 1 | Selects force-bit clearing on acknowledge |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| ack_valid | input | 1 | Processor acknowledge strobe |
| ack_level | input | 4 | Level being acknowledged |
| irq_valid | output | 1 | One-cycle offer strobe |
| irq_level | output | 4 | Level being offered |

## Verification
The hardest situation to reach is an acknowledge that leaves a level still requesting. This needs a force bit and the normal acknowledge mode, so that the pending bit is cleared while the force bit keeps the request alive and the level must be offered again. The bench sets force bits while level 15 alone escapes the mask, so the unmaskable level is offered, acknowledged, offered again and then retired through the test-mode path. The bench also sweeps single requests over every level, and runs several mask and force patterns to check that the offer order is strictly descending.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    RA_PEND  = 2'd0,
    RA_MASK  = 2'd1,
    RA_FORCE = 2'd2,
    RA_CLEAR = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irqc_prio_pick.sv
module irqc_prio_pick #(
  parameter int NLVL = 16,
  parameter int LW   = $clog2(NLVL)
) (
  input  logic [NLVL-1:0] vec,
  output logic            any,
  output logic [LW-1:0]   lvl
);
  // Ascending scan: the last hit is the highest level; bit 0 is never scanned.
  function automatic logic [LW:0] top_of(input logic [NLVL-1:0] v);
    logic [LW:0] r;
    r = '0;
    for (int i = 1; i < NLVL; i++)
      if (v[i]) r = {1'b1, LW'(i)};
    return r;
  endfunction

  logic [LW:0] pick_w;
  assign pick_w = top_of(vec);
  assign any    = pick_w[LW];
  assign lvl    = pick_w[LW-1:0];
endmodule

// File: rtl/irqc_level_regs.sv
module irqc_level_regs
  import irqc_pkg::*;
#(
  parameter int              NLVL      = 16,
  parameter int              LW        = $clog2(NLVL),
  parameter logic [NLVL-1:0] MASK_RST  = 16'h3FFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLVL-1:0] req_pulse,
  input  logic            test_mode,
  input  logic            reg_we,
  input  logic [1:0]      reg_addr,
  input  logic [NLVL-1:0] reg_wdata,
  output logic [NLVL-1:0] reg_rdata,
  input  logic            ack_valid,
  input  logic [LW-1:0]   ack_level,
  output logic [NLVL-1:0] pend_q,
  output logic [NLVL-1:0] force_q,
  output logic [NLVL-1:0] mask_q
);
  localparam logic [NLVL-1:0] ONE       = NLVL'(1);
  localparam logic [NLVL-1:0] LVL_KEEP  = ~ONE;
  localparam logic [NLVL-1:0] MASK_KEEP = LVL_KEEP & ~(ONE << (NLVL-1));

  reg_addr_e addr_w;
  assign addr_w = reg_addr_e'(reg_addr);

  // Named internal events
  logic [NLVL-1:0] ack_vec_w, pend_set_w, clr_vec_w, ack_pend_clr_w, ack_force_clr_w;
  logic            ack_hits_force_w, wr_mask_w, wr_force_w;

  assign ack_vec_w        = ack_valid ? ((ONE << ack_level) & LVL_KEEP) : '0;
  assign ack_hits_force_w = ack_valid && test_mode && force_q[ack_level];
  assign ack_force_clr_w  = ack_hits_force_w ? ack_vec_w : '0;
  assign ack_pend_clr_w   = ack_hits_force_w ? '0 : ack_vec_w;
  assign pend_set_w       = req_pulse & LVL_KEEP;
  assign clr_vec_w        = (reg_we && addr_w == RA_CLEAR) ? reg_wdata : '0;
  assign wr_mask_w        = reg_we && addr_w == RA_MASK;
  assign wr_force_w       = reg_we && addr_w == RA_FORCE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '0;
      force_q <= '0;
      mask_q  <= MASK_RST;
    end else begin
      pend_q <= (pend_q & ~clr_vec_w & ~ack_pend_clr_w) | pend_set_w;
      if (wr_force_w) force_q <= reg_wdata & LVL_KEEP;
      else            force_q <= force_q & ~ack_force_clr_w;
      if (wr_mask_w)  mask_q  <= reg_wdata & MASK_KEEP;
    end
  end

  always_comb begin
    case (addr_w)
      RA_PEND:  reg_rdata = pend_q;
      RA_MASK:  reg_rdata = mask_q;
      RA_FORCE: reg_rdata = force_q;
      default:  reg_rdata = '0;
    endcase
  end

  AST_REQ_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend_set_w) |=> ((pend_q & $past(pend_set_w)) == $past(pend_set_w))); // R8
  AST_ACK_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !(test_mode && force_q[ack_level]) && !req_pulse[ack_level])
      |=> !pend_q[$past(ack_level)]); // R6
  AST_TEST_ACK_CLEARS_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && test_mode && force_q[ack_level] && !wr_force_w)
      |=> !force_q[$past(ack_level)]); // R7
  AST_TOP_UNMASKABLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask_w |=> !mask_q[NLVL-1]); // R4
endmodule

// File: rtl/irqc_presenter.sv
module irqc_presenter #(
  parameter int NLVL = 16,
  parameter int LW   = $clog2(NLVL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLVL-1:0] active,
  input  logic            ack_valid,
  input  logic [LW-1:0]   ack_level,
  output logic            irq_valid,
  output logic [LW-1:0]   irq_level
);
  localparam logic [NLVL-1:0] ONE = NLVL'(1);

  logic [NLVL-1:0] posted_q, avail_w, post_set_w, post_clr_w;
  logic            pick_any_w;
  logic [LW-1:0]   pick_lvl_w;

  assign avail_w = active & ~posted_q;

  irqc_prio_pick #(.NLVL(NLVL), .LW(LW)) u_pick (
    .vec(avail_w), .any(pick_any_w), .lvl(pick_lvl_w)
  );

  assign post_set_w = pick_any_w ? (ONE << pick_lvl_w) : '0;
  assign post_clr_w = ack_valid  ? (ONE << ack_level)  : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      posted_q  <= '0;
      irq_valid <= 1'b0;
      irq_level <= '0;
    end else begin
      posted_q  <= (posted_q | post_set_w) & ~post_clr_w;  // acknowledge wins
      irq_valid <= pick_any_w;
      irq_level <= pick_lvl_w;
    end
  end

  AST_NO_LEVEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_level != '0)); // R1
  AST_OFFER_WAS_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ((($past(avail_w) >> irq_level) & ONE) != '0)); // R2
  AST_OFFER_IS_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ((($past(avail_w) >> irq_level) >> 1) == '0)); // R2
  AST_OFFER_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !ack_valid) |=> !(irq_valid && irq_level == $past(irq_level))); // R3
endmodule

// File: rtl/irqc15_top.sv
module irqc15_top #(
  parameter int              NLVL     = 16,
  parameter int              LW       = $clog2(NLVL),
  parameter logic [NLVL-1:0] MASK_RST = 16'h3FFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLVL-1:0] req_pulse,
  input  logic            test_mode,
  input  logic            reg_we,
  input  logic [1:0]      reg_addr,
  input  logic [NLVL-1:0] reg_wdata,
  output logic [NLVL-1:0] reg_rdata,
  input  logic            ack_valid,
  input  logic [LW-1:0]   ack_level,
  output logic            irq_valid,
  output logic [LW-1:0]   irq_level
);
  logic [NLVL-1:0] pend_w, force_w, mask_w, active_w;

  irqc_level_regs #(.NLVL(NLVL), .LW(LW), .MASK_RST(MASK_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .req_pulse(req_pulse), .test_mode(test_mode),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ack_valid(ack_valid), .ack_level(ack_level),
    .pend_q(pend_w), .force_q(force_w), .mask_q(mask_w)
  );

  assign active_w = (pend_w | force_w) & ~mask_w & ~NLVL'(1);

  irqc_presenter #(.NLVL(NLVL), .LW(LW)) u_pres (
    .clk(clk), .rst_n(rst_n), .active(active_w),
    .ack_valid(ack_valid), .ack_level(ack_level),
    .irq_valid(irq_valid), .irq_level(irq_level)
  );

  AST_MASKED_NOT_OFFERED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ((($past(mask_w) >> irq_level) & NLVL'(1)) == '0)); // R4
endmodule

// File: tb/tb_irqc15_top.sv
module tb_irqc15_top;
  logic        clk = 0, rst_n = 0;
  logic [15:0] req_pulse = 0;
  logic        test_mode = 0, reg_we = 0, ack_valid = 0;
  logic [1:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic [3:0]  ack_level = 0, irq_level;
  logic        irq_valid;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  irqc15_top dut (.*);

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic check(string rq, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d; tick(); reg_we = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic ack(logic [3:0] l, logic tm);
    ack_valid = 1; ack_level = l; test_mode = tm; tick(); ack_valid = 0; test_mode = 0;
  endtask

  function automatic int highest(logic [15:0] v);
    for (int i = 15; i >= 1; i--) if (v[i]) return i;
    return 0;
  endfunction

  logic [15:0] d;

  initial begin
    repeat (3) tick();
    rst_n = 1;
    // R10 / R4 / R5: reset state
    check("R10 valid at reset", {15'd0, irq_valid}, 16'd0);
    rd(0, d); check("R10 pending reset", d, 16'h0000);
    rd(1, d); check("R4 mask reset", d, 16'h3FFF);
    rd(2, d); check("R5 force reset", d, 16'h0000);
    rd(3, d); check("R9 clear reads zero", d, 16'h0000);
    // R4: mask write keeps 14..1
    wr(1, 16'hFFFF); rd(1, d); check("R4 mask keep", d, 16'h7FFE);
    // R5 + R4: force all; only level 15 is unmasked
    wr(2, 16'hFFFF); rd(2, d); check("R5 force keep", d, 16'hFFFE);
    tick(); check("R4 level15 offered", {11'd0, irq_valid, irq_level}, 16'h001F);
    tick(); check("R3 no repeat", {15'd0, irq_valid}, 16'd0);
    tick(); check("R3 no repeat later", {15'd0, irq_valid}, 16'd0);
    ack(15, 0); // R6: pending cleared, force kept -> re-offer
    rd(2, d); check("R6 force kept", d, 16'hFFFE);
    tick(); check("R3 re-offer after ack", {11'd0, irq_valid, irq_level}, 16'h001F);
    ack(15, 1);
    rd(2, d); check("R7 test ack clears force", d, 16'h7FFE);
    wr(2, 16'h0000);
    // R6/R7 with masked level 3
    req_pulse = 16'h0008; tick(); req_pulse = 0;
    wr(2, 16'h0008);
    rd(0, d); check("R8 pending set", d, 16'h0008);
    ack(3, 0);
    rd(0, d); check("R6 pending cleared", d, 16'h0000);
    rd(2, d); check("R6 force unchanged", d, 16'h0008);
    req_pulse = 16'h0008; tick(); req_pulse = 0;
    ack(3, 1);
    rd(2, d); check("R7 force cleared", d, 16'h0000);
    rd(0, d); check("R7 pending kept", d, 16'h0008);
    ack(3, 1);
    rd(0, d); check("R7 fallback clears pending", d, 16'h0000);
    // R9 clear register
    req_pulse = 16'h0088; tick(); req_pulse = 0;
    wr(3, 16'h0008); rd(0, d); check("R9 partial clear", d, 16'h0080);
    // R8 set wins over clear and ack
    req_pulse = 16'h0080; wr(3, 16'h0080); req_pulse = 0;
    rd(0, d); check("R8 set beats clear", d, 16'h0080);
    req_pulse = 16'h0080; ack(7, 0); req_pulse = 0;
    rd(0, d); check("R8 set beats ack", d, 16'h0080);
    wr(3, 16'hFFFF); rd(0, d); check("R9 full clear", d, 16'h0000);
    check("R4 masked not offered", {15'd0, irq_valid}, 16'd0);
    // unmask all; sweep every level
    wr(1, 16'h0000);
    for (int l = 1; l < 16; l++) begin
      req_pulse = 16'(1) << l; tick(); req_pulse = 0;
      check("R10 not yet", {15'd0, irq_valid}, 16'd0);
      tick(); check("R10 offer level", {11'd0, irq_valid, irq_level}, 16'(16 + l));
      tick(); check("R3 single offer", {15'd0, irq_valid}, 16'd0);
      rd(0, d); check("R8 pending bit", d, 16'(1) << l);
      ack(4'(l), 0);
      rd(0, d); check("R6 cleared by ack", d, 16'h0000);
      tick(); tick(); check("R3 quiet after ack", {15'd0, irq_valid}, 16'd0);
    end
    // R1: level 0
    req_pulse = 16'h0001; tick(); req_pulse = 0;
    tick(); check("R1 no level0 offer", {15'd0, irq_valid}, 16'd0);
    tick(); check("R1 no level0 offer", {15'd0, irq_valid}, 16'd0);
    rd(0, d); check("R1 pending bit0", d, 16'h0000);
    // R2 priority order over mask/force patterns
    begin
      logic [15:0] fp [5] = '{16'hFFFE, 16'hA5A5, 16'h8002, 16'h0001, 16'h0FF0};
      logic [15:0] mp [5] = '{16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0F00};
      for (int p = 0; p < 5; p++) begin
        logic [15:0] rem;
        int bad;
        wr(1, mp[p]);
        wr(2, fp[p]);
        rem = fp[p] & ~(mp[p] & 16'h7FFE) & 16'hFFFE;
        bad = 0;
        for (int t = 0; t < 20; t++) begin
          tick();
          if (irq_valid) begin
            check("R2 descending offer", {12'd0, irq_level}, 16'(highest(rem)));
            rem[irq_level] = 1'b0;
          end
        end
        check("R2 all offered once", rem, 16'h0000);
        for (int l = 1; l < 16; l++) if (fp[p][l]) ack(4'(l), 1);
        rd(2, d); check("R7 force drained", d, 16'h0000);
        tick(); tick(); check("R3 quiet after drain", {15'd0, irq_valid}, 16'd0);
        wr(1, 16'h0000);
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule